// File: doc/BRIEF.md
# Hot-plug detect interrupt unit

This block watches a display hot-plug detect line and turns it into interrupt events that software can use. The raw line is first brought into the clock domain by two flip-flops. A filter with a programmable tick rate then keeps the level until the new value has stayed steady for a programmed number of ticks. Each change of the filtered level latches its own status bit, one for connect and one for disconnect. An interrupt request from the attached core controller shares the same status word.

Software reaches the block through a simple synchronous register port. It sets up the filter, reads and clears the latched events, enables the sources that may drive the single interrupt output, and reads the current filtered level. The interrupt output is a level signal. It stays asserted until every enabled, latched cause has been cleared.

Top module: `hpd_intr_top`

## Requirements
- R1: After reset the status bits, the enable mask, the filtered level and `irqOut` are all 0, and the filter register reads 0x0000A0A0 (tick divider 0xA, stable count 0xA0).
- R2: The raw input passes through a two-flop synchronizer. The filtered level takes a new value only after the synchronized input has differed from it on N consecutive ticks, where N is the stable count (a count of 0 acts as 1). A pulse shorter than N ticks leaves the level unchanged.
- R3: The filter ticks once every D+1 clocks, where D is the divider field in bits 15:12 of the filter register (address 0).
- R4: A 0-to-1 change of the filtered level sets status bit 1, and a 1-to-0 change sets status bit 2. The status register is at address 1.
- R5: Any cycle in which `coreIrq` is high sets status bit 0, and the bit stays set after `coreIrq` falls.
- R6: Writing to address 2 clears each status bit whose write-data bit is 1 and leaves the other bits alone. If a bit is set and cleared in the same cycle, the set wins. Address 2 reads 0.
- R7: `irqOut` is high exactly when some status bit is 1 and its enable bit in the mask register (address 3, bits 2:0, 1 = enabled) is also 1. A status bit whose enable is 0 still latches but does not drive `irqOut`.
- R8: Address 4 reads 1 in bit 0 while the filtered level is high and reads 0 otherwise.
- R9: Read data appears on `busRdData`, with `busRdValid` high, in the cycle after `busRdEn`. In any other cycle `busRdValid` is low. Unmapped addresses read 0, and writes to them change nothing.
- R10: The filter register keeps only bits 15:12 and bits 7:0 of the written data. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hpdRaw | input | 1 | Asynchronous raw hot-plug level |
| coreIrq | input | 1 | Interrupt request from the core controller |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 3 | Register word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid one cycle after the read strobe |
| busRdValid | output | 1 | Marks read data as valid |
| irqOut | output | 1 | Combined level interrupt |

## Verification
The filter is driven with a pulse one tick shorter than the stable count, which must be rejected, and with a steady level, which must be accepted. Each is probed before and after the expected flip point, so an off-by-one in the count or a missing synchronizer stage shows up. A second run with a slower tick rate reads the level at a point where an undivided tick would already have flipped it. Rise, fall and core events are combined with different mask patterns and with clear writes that hit or miss the set bits. This separates masking from latching and clear-by-one from clear-all. A clear issued while `coreIrq` is still high confirms that a set in the same cycle wins over the clear.

// File: rtl/hpd_intr_pkg.sv
package hpd_intr_pkg;

  // register word addresses
  localparam int ADR_CFG   = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_CLR   = 2;
  localparam int ADR_MASK  = 3;
  localparam int ADR_LEVEL = 4;

  // status bit positions
  localparam int BIT_CORE = 0;
  localparam int BIT_RISE = 1;
  localparam int BIT_FALL = 2;
  localparam int NUM_SRC  = 3;

  typedef enum logic [2:0] {
    SEL_CFG   = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_CLR   = 3'd2,
    SEL_MASK  = 3'd3,
    SEL_LEVEL = 3'd4,
    SEL_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    cfgWr;
    logic    clrWr;
    logic    maskWr;
    logic    rdReq;
    regSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/hpd_intr_ctrl.sv
module hpd_intr_ctrl
  import hpd_intr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          stb,
  output logic              busRdValid
);

  regSel_e sel;

  // address decode
  always_comb begin
    if (busAddr == ADDR_W'(ADR_CFG))        sel = SEL_CFG;
    else if (busAddr == ADDR_W'(ADR_STAT))  sel = SEL_STAT;
    else if (busAddr == ADDR_W'(ADR_CLR))   sel = SEL_CLR;
    else if (busAddr == ADDR_W'(ADR_MASK))  sel = SEL_MASK;
    else if (busAddr == ADDR_W'(ADR_LEVEL)) sel = SEL_LEVEL;
    else                                    sel = SEL_NONE;
  end

  always_comb begin
    stb.cfgWr  = busWrEn && (sel == SEL_CFG);
    stb.clrWr  = busWrEn && (sel == SEL_CLR);
    stb.maskWr = busWrEn && (sel == SEL_MASK);
    stb.rdReq  = busRdEn;
    stb.rdSel  = sel;
  end

  // read data is registered in the datapath, so valid trails the request by one cycle
  always_ff @(posedge clk) begin
    if (!rstN) busRdValid <= 1'b0;
    else       busRdValid <= busRdEn;
  end

endmodule

// File: rtl/hpd_intr_dp.sv
module hpd_intr_dp
  import hpd_intr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 4,
  parameter int DIV_LSB   = 12,
  parameter int CNT_W     = 8,
  parameter int DIV_RESET = 10,
  parameter int CNT_RESET = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hpdRaw,
  input  logic              coreIrq,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              levelQ,
  output logic [NUM_SRC-1:0] statQ
);

  localparam int CFG_W = DIV_LSB + DIV_W;
  localparam logic [CFG_W-1:0] DIV_FIELD = {{(CFG_W-DIV_W){1'b0}}, {DIV_W{1'b1}}} << DIV_LSB;
  localparam logic [CFG_W-1:0] CNT_FIELD = {{(CFG_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};
  localparam logic [CFG_W-1:0] CFG_KEEP  = DIV_FIELD | CNT_FIELD;
  localparam logic [CFG_W-1:0] CFG_INIT  =
    (CFG_W'(DIV_RESET) << DIV_LSB) | (CFG_W'(CNT_RESET) & CNT_FIELD);

  logic [CFG_W-1:0]   cfgQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [1:0]         syncQ;
  logic [DIV_W-1:0]   preQ;
  logic [CNT_W-1:0]   stabQ;
  logic [DIV_W-1:0]   divVal;
  logic [CNT_W-1:0]   needVal;
  logic               sampled;
  logic               tick;
  logic               mismatch;
  logic [CNT_W:0]     cntNext;
  logic               flip;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;

  assign divVal  = cfgQ[DIV_LSB +: DIV_W];
  assign needVal = cfgQ[CNT_W-1:0];

  // configuration and mask registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ  <= CFG_INIT;
      maskQ <= '0;
    end else begin
      if (stb.cfgWr)  cfgQ  <= wrData[CFG_W-1:0] & CFG_KEEP;
      if (stb.maskWr) maskQ <= wrData[NUM_SRC-1:0];
    end
  end

  // two-flop synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], hpdRaw};
  end
  assign sampled = syncQ[1];

  // tick prescaler: one tick every divVal+1 clocks
  assign tick = (preQ == divVal);
  always_ff @(posedge clk) begin
    if (!rstN)     preQ <= '0;
    else if (tick) preQ <= '0;
    else           preQ <= preQ + 1'b1;
  end

  // stable-sample filter
  assign mismatch = (sampled != levelQ);
  assign cntNext  = {1'b0, stabQ} + 1'b1;
  assign flip     = tick && mismatch && (cntNext >= {1'b0, needVal});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stabQ  <= '0;
      levelQ <= 1'b0;
    end else if (!mismatch) begin
      stabQ <= '0;
    end else if (tick) begin
      if (flip) begin
        stabQ  <= '0;
        levelQ <= ~levelQ;
      end else begin
        stabQ <= cntNext[CNT_W-1:0];
      end
    end
  end

  // event sources and write-one-to-clear
  always_comb begin
    setVec           = '0;
    setVec[BIT_CORE] = coreIrq;
    setVec[BIT_RISE] = flip && !levelQ;
    setVec[BIT_FALL] = flip && levelQ;
    clrVec = stb.clrWr ? wrData[NUM_SRC-1:0] : '0;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN)          statQ[i] <= 1'b0;
      else if (setVec[i]) statQ[i] <= 1'b1;
      else if (clrVec[i]) statQ[i] <= 1'b0;
    end
  end

  assign irqOut = |(statQ & maskQ);

  // registered read mux
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdReq) begin
      case (stb.rdSel)
        SEL_CFG:   rdData <= DATA_W'(cfgQ);
        SEL_STAT:  rdData <= DATA_W'(statQ);
        SEL_MASK:  rdData <= DATA_W'(maskQ);
        SEL_LEVEL: rdData <= DATA_W'(levelQ);
        default:   rdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/hpd_intr_top.sv
module hpd_intr_top
  import hpd_intr_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 4,
  parameter int DIV_LSB   = 12,
  parameter int CNT_W     = 8,
  parameter int DIV_RESET = 10,
  parameter int CNT_RESET = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hpdRaw,
  input  logic              coreIrq,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdValid,
  output logic              irqOut
);

  strobes_t           stb;
  logic               levelW;
  logic [NUM_SRC-1:0] statW;

  hpd_intr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .stb        (stb),
    .busRdValid (busRdValid)
  );

  hpd_intr_dp #(
    .DATA_W    (DATA_W),
    .DIV_W     (DIV_W),
    .DIV_LSB   (DIV_LSB),
    .CNT_W     (CNT_W),
    .DIV_RESET (DIV_RESET),
    .CNT_RESET (CNT_RESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .hpdRaw  (hpdRaw),
    .coreIrq (coreIrq),
    .stb     (stb),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .irqOut  (irqOut),
    .levelQ  (levelW),
    .statQ   (statW)
  );

endmodule

// File: rtl/hpd_intr_checker.sv
module hpd_intr_checker
  import hpd_intr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               hpdRaw,
  input logic               coreIrq,
  input logic               busWrEn,
  input logic               busRdEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic               busRdValid,
  input logic               irqOut,
  input logic               levelW,
  input logic [NUM_SRC-1:0] statW
);

  logic clrHit;
  assign clrHit = busWrEn && (busAddr == ADDR_W'(ADR_CLR));

  // R9: valid follows a read request by exactly one cycle
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);
  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid);

  // R7: the interrupt can only drop after a register write
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !busWrEn) |=> irqOut);

  // R2: a new filtered level always matches the raw input seen through the synchronizer
  p_level_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    (levelW != $past(levelW)) |-> (levelW == $past(hpdRaw, 3)));

  // R4: edge status bits are set together with the matching level change
  p_rise_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statW[BIT_RISE]) |-> $rose(levelW));
  p_fall_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statW[BIT_FALL]) |-> $fell(levelW));

  // R5: the core request latches into bit 0
  p_core_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    coreIrq |=> statW[BIT_CORE]);

  // R6: a latched bit only drops after a clear write naming it
  p_rise_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statW[BIT_RISE]) |-> $past(clrHit && busWrData[BIT_RISE]));
  p_fall_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statW[BIT_FALL]) |-> $past(clrHit && busWrData[BIT_FALL]));

endmodule

bind hpd_intr_top hpd_intr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hpdRaw     (hpdRaw),
  .coreIrq    (coreIrq),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .busRdValid (busRdValid),
  .irqOut     (irqOut),
  .levelW     (levelW),
  .statW      (statW)
);

// File: tb/hpd_intr_top_bench.sv
module hpd_intr_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hpdRaw = 1'b0;
  logic        coreIrq = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] expQ [$];
  string       tagQ [$];

  always #4 clk = ~clk;

  hpd_intr_top u_hpd_intr_top (
    .clk        (clk),
    .rstN       (rstN),
    .hpdRaw     (hpdRaw),
    .coreIrq    (coreIrq),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .busRdValid (busRdValid),
    .irqOut     (irqOut)
  );

  // monitor: pops the expected read value when the design presents data
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read data actual=%h expected=none", busRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdData !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, busRdData, e);
        end
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: issue a read and queue its expected value
  task automatic rdExp(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busRdEn = 1'b1;
    busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn   = 1'b1;
    busAddr   = a;
    busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic chkBit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", t, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    chkBit(irqOut, 1'b0, "R1 irq after reset");
    chkBit(busRdValid, 1'b0, "R9 valid idle");
    rdExp(3'd0, 32'h0000A0A0, "R1 cfg reset");
    rdExp(3'd1, 32'h0, "R1 status reset");
    rdExp(3'd3, 32'h0, "R1 mask reset");
    rdExp(3'd4, 32'h0, "R1 level reset");

    // R10 field masking; leaves divider 0, count 4
    wr(3'd0, 32'hABCD0F04);
    rdExp(3'd0, 32'h00000004, "R10 cfg readback");
    rdExp(3'd2, 32'h0, "R6 clear reads zero");

    // R2 glitch of 3 ticks rejected
    @(negedge clk); hpdRaw = 1'b1;
    waitCyc(3);     hpdRaw = 1'b0;
    waitCyc(10);
    rdExp(3'd4, 32'h0, "R2 glitch rejected");
    rdExp(3'd1, 32'h0, "R2 no event from glitch");

    // R2 / R8 steady level accepted, not too early
    @(negedge clk); hpdRaw = 1'b1;
    waitCyc(1);
    rdExp(3'd4, 32'h0, "R2 level not yet changed");
    waitCyc(10);
    rdExp(3'd4, 32'h1, "R8 level high");
    rdExp(3'd1, 32'h2, "R4 rise latched");
    chkBit(irqOut, 1'b0, "R7 masked rise no irq");

    // R7 enable rise
    wr(3'd3, 32'h2);
    waitCyc(1);
    chkBit(irqOut, 1'b1, "R7 irq enabled rise");

    // R6 clear of an unset bit leaves others
    wr(3'd2, 32'h4);
    waitCyc(1);
    rdExp(3'd1, 32'h2, "R6 partial clear keeps bit1");
    chkBit(irqOut, 1'b1, "R6 irq still high");
    wr(3'd2, 32'h2);
    waitCyc(1);
    chkBit(irqOut, 1'b0, "R6 irq cleared");
    rdExp(3'd1, 32'h0, "R6 status cleared");

    // R4 fall, latched while masked
    @(negedge clk); hpdRaw = 1'b0;
    waitCyc(12);
    rdExp(3'd4, 32'h0, "R8 level low");
    rdExp(3'd1, 32'h4, "R4 fall latched");
    chkBit(irqOut, 1'b0, "R7 fall masked");
    wr(3'd3, 32'h7);
    waitCyc(1);
    chkBit(irqOut, 1'b1, "R7 fall enabled");
    wr(3'd2, 32'h4);
    waitCyc(1);
    chkBit(irqOut, 1'b0, "R6 fall cleared");

    // R5 one-cycle core pulse is sticky
    @(negedge clk); coreIrq = 1'b1;
    @(negedge clk); coreIrq = 1'b0;
    waitCyc(3);
    rdExp(3'd1, 32'h1, "R5 core latched");
    chkBit(irqOut, 1'b1, "R5 core irq");
    wr(3'd2, 32'h1);
    waitCyc(1);
    chkBit(irqOut, 1'b0, "R5 core cleared");

    // R6 set wins while the core request persists
    @(negedge clk); coreIrq = 1'b1;
    wr(3'd2, 32'h1);
    waitCyc(1);
    rdExp(3'd1, 32'h1, "R6 set wins over clear");
    @(negedge clk); coreIrq = 1'b0;
    wr(3'd2, 32'h7);
    rdExp(3'd1, 32'h0, "R6 clear all");

    // R9 unmapped address
    wr(3'd7, 32'hFFFFFFFF);
    rdExp(3'd7, 32'h0, "R9 unmapped reads zero");
    rdExp(3'd0, 32'h00000004, "R9 unmapped write ignored cfg");
    rdExp(3'd3, 32'h7, "R9 unmapped write ignored mask");

    // R3 slower ticks: divider 3, count 4
    wr(3'd0, 32'h00003004);
    @(negedge clk); hpdRaw = 1'b1;
    waitCyc(5);
    rdExp(3'd4, 32'h0, "R3 prescaled level still low");
    waitCyc(30);
    rdExp(3'd4, 32'h1, "R3 prescaled level high");

    waitCyc(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R9 reads outstanding actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule